// File: doc/BRIEF.md
# Shadow RAM region control unit

This block is the configuration and routing front end for the upper memory area of a PC-compatible board. The CPU programs it through two I/O ports. A write to the index port selects one of 256 byte-wide configuration registers. A write to the data port stores a byte into the selected register, and a read of the data port returns it.

A combinational decoder then classifies every memory access by its 16 KB page number. Each access goes to one of three places: on-board DRAM, the external expansion bus, or nowhere (a write that is silently dropped). The two video segments carry their own internal/external mapping bits. The seven option-ROM and system-ROM segments each have an independent shadow-read enable and shadow-write enable. A global write-protect flag, together with a per-segment write-protect mask, blocks ROM-area writes only where shadow writing is off.

The block also emits a one-cycle strobe whenever the wait-state register is written, and a level enable for the fast-reset port.

Top module: `shadow_ctl`

## Requirements
- R1: An I/O write to port 0x22 loads the index. An I/O write to port 0x23 stores the byte into the indexed register on that clock edge. An I/O read of port 0x23 returns the indexed register in the same cycle.
- R2: `io_rdata` is 0xFF whenever `io_rd` is low or `io_addr` is not 0x23. A write to port 0x22 leaves every register's content unchanged.
- R3: After reset, register 0x05 reads 0x05, register 0x1B reads 0x60, and every other register reads 0x00.
- R4: Pages 40–43 (0xA0000) route to internal when register 0x18 bit 0 is set, else external. Pages 44–47 (0xB0000) do the same with bit 1. This applies to reads and writes alike.
- R5: Segment n is numbered as follows: pages 48–51 are segments 0–3, pages 52–55 are segment 4, pages 56–59 are segment 5, and pages 60–63 are segment 6. A read in segment n routes internal if register 0x19 bit n is set, else external.
- R6: A write in segment n routes internal when register 0x1A bit n is set, whatever register 0x1B holds.
- R7: With register 0x1A bit n clear, a write in segment n is blocked when register 0x1B bit 7 and bit n are both set; otherwise it routes external. A read is never blocked.
- R8: A data-port write while the index is 0x06 raises `ws_update` for exactly the next cycle. No other write raises it.
- R9: `fastrst_en` equals bit 5 of register 0x1C.
- R10: Pages 0–39 (below 0xA0000) always route internal. Exactly one of `route_int`, `route_ext` and `route_blk` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| io_rd | input | 1 | I/O read qualifier |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| mem_page | input | 6 | Memory address bits 19:14 (16 KB page) |
| mem_write | input | 1 | Access is a write |
| route_int | output | 1 | Access goes to internal DRAM |
| route_ext | output | 1 | Access goes to the expansion bus |
| route_blk | output | 1 | Write is discarded |
| ws_update | output | 1 | Wait-state register was written |
| fastrst_en | output | 1 | Fast-reset port enable |

## Verification
The assertions assume the following about the inputs:
- Reset is held for at least one edge before they are enabled.
- Every I/O write is a single-cycle strobe, so a `ws_update` pulse can always be traced to a write one cycle earlier.
- `mem_page` and `mem_write` are known values, so the route outputs can be treated as one-hot.

The stimulus keeps within these assumptions as follows:
- It changes every input on the falling edge and issues each write as a one-cycle strobe.
- It sweeps all 64 pages for both reads and writes under many register patterns.
- It samples the combinational outputs a moment after the inputs settle.

// File: rtl/shadow_ctl.sv
module shadow_ctl #(
  parameter int            IO_AW     = 16,
  parameter logic [15:0]   IDX_PORT  = 16'h0022,
  parameter logic [15:0]   DATA_PORT = 16'h0023,
  parameter int            IDX_W     = 8,
  parameter int            PAGE_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [PAGE_W-1:0] mem_page,
  input  logic              mem_write,
  output logic              route_int,
  output logic              route_ext,
  output logic              route_blk,
  output logic              ws_update,
  output logic              fastrst_en
);
  localparam int NREG = 1 << IDX_W;
  localparam logic [IDX_W-1:0] R_WAIT  = IDX_W'(8'h06);
  localparam logic [IDX_W-1:0] R_VIDEO = IDX_W'(8'h18);
  localparam logic [IDX_W-1:0] R_SHRD  = IDX_W'(8'h19);
  localparam logic [IDX_W-1:0] R_SHWR  = IDX_W'(8'h1A);
  localparam logic [IDX_W-1:0] R_WPROT = IDX_W'(8'h1B);
  localparam logic [IDX_W-1:0] R_MISC  = IDX_W'(8'h1C);

  logic [IDX_W-1:0] idx;
  logic [7:0]       regs [NREG];

  wire idx_we  = io_wr && (io_addr == IO_AW'(IDX_PORT));
  wire data_we = io_wr && (io_addr == IO_AW'(DATA_PORT));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      ws_update <= 1'b0;
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == 5) ? 8'h05 : (i == 8'h1B) ? 8'h60 : 8'h00;
    end else begin
      ws_update <= data_we && (idx == R_WAIT);
      if (idx_we) idx <= io_wdata[IDX_W-1:0];
      if (data_we) regs[idx] <= io_wdata;
    end
  end

  assign io_rdata   = (io_rd && io_addr == IO_AW'(DATA_PORT)) ? regs[idx] : 8'hFF;
  assign fastrst_en = regs[R_MISC][5];

  wire [7:0] video = regs[R_VIDEO];
  wire [7:0] shrd  = regs[R_SHRD];
  wire [7:0] shwr  = regs[R_SHWR];
  wire [7:0] wprot = regs[R_WPROT];

  wire [3:0] seg64 = mem_page[PAGE_W-1 -: 4];
  logic [2:0] seg;
  logic       in_rom, in_vid, vid_int;

  always_comb begin
    seg     = 3'd0;
    in_rom  = 1'b0;
    in_vid  = 1'b0;
    vid_int = 1'b0;
    case (seg64)
      4'hA: begin in_vid = 1'b1; vid_int = video[0]; end
      4'hB: begin in_vid = 1'b1; vid_int = video[1]; end
      4'hC: begin in_rom = 1'b1; seg = {1'b0, mem_page[1:0]}; end
      4'hD: begin in_rom = 1'b1; seg = 3'd4; end
      4'hE: begin in_rom = 1'b1; seg = 3'd5; end
      4'hF: begin in_rom = 1'b1; seg = 3'd6; end
      default: ;
    endcase
  end

  wire wr_locked = wprot[7] && wprot[seg];

  always_comb begin
    route_int = 1'b1;
    route_ext = 1'b0;
    route_blk = 1'b0;
    if (in_vid) begin
      route_int = vid_int;
      route_ext = !vid_int;
    end else if (in_rom) begin
      if (!mem_write) begin
        route_int = shrd[seg];
        route_ext = !shrd[seg];
      end else if (shwr[seg]) begin
        route_int = 1'b1;
      end else begin
        route_int = 1'b0;
        route_ext = !wr_locked;
        route_blk = wr_locked;
      end
    end
  end

  p_route_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot({route_int, route_ext, route_blk}));

  p_read_never_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_write |-> !route_blk);

  p_low_area_internal_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_page < PAGE_W'(40)) |-> route_int);

  p_ws_follows_write_r8: assert property (@(posedge clk) disable iff (rst)
    ws_update |-> $past(io_wr));

  p_ws_single_r8: assert property (@(posedge clk) disable iff (rst)
    (ws_update && !$past(io_wr, 2)) |=> !ws_update);

  p_fastrst_by_write_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(fastrst_en) |-> $past(io_wr));
endmodule

// File: tb/sim_shadow_ctl.sv
module sim_shadow_ctl;
  logic clk = 0, rst = 1;
  logic io_wr = 0, io_rd = 0, mem_write = 0;
  logic [15:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic [5:0] mem_page = 0;
  logic route_int, route_ext, route_blk, ws_update, fastrst_en;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  shadow_ctl u0 (.clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_page(mem_page), .mem_write(mem_write),
    .route_int(route_int), .route_ext(route_ext), .route_blk(route_blk),
    .ws_update(ws_update), .fastrst_en(fastrst_en));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic iow(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic setreg(logic [7:0] i, logic [7:0] d);
    iow(16'h22, i); iow(16'h23, d);
  endtask

  task automatic ior(logic [7:0] i, output logic [7:0] d);
    iow(16'h22, i);
    io_addr = 16'h23; io_rd = 1; #1 d = io_rdata; io_rd = 0;
  endtask

  function automatic logic [2:0] exp_route(int pg, bit wr, logic [7:0] v, logic [7:0] r,
                                           logic [7:0] w, logic [7:0] p);
    int s;
    if (pg < 40) return 3'b100;
    if (pg < 44) return v[0] ? 3'b100 : 3'b010;
    if (pg < 48) return v[1] ? 3'b100 : 3'b010;
    s = (pg < 52) ? pg - 48 : 4 + (pg - 52) / 4;
    if (!wr) return r[s] ? 3'b100 : 3'b010;
    if (w[s]) return 3'b100;
    return (p[7] && p[s]) ? 3'b001 : 3'b010;
  endfunction

  function automatic string tag(int pg, bit wr, logic [7:0] w);
    int s;
    if (pg < 40) return "R10";
    if (pg < 48) return "R4";
    if (!wr) return "R5";
    s = (pg < 52) ? pg - 48 : 4 + (pg - 52) / 4;
    return w[s] ? "R6" : "R7";
  endfunction

  task automatic sweep(logic [7:0] v, logic [7:0] r, logic [7:0] w, logic [7:0] p);
    setreg(8'h18, v); setreg(8'h19, r); setreg(8'h1A, w); setreg(8'h1B, p);
    for (int pg = 0; pg < 64; pg++)
      for (int wr = 0; wr < 2; wr++) begin
        mem_page = 6'(pg); mem_write = wr[0];
        #1 chk(tag(pg, wr[0], w), {5'd0, route_int, route_ext, route_blk},
               {5'd0, exp_route(pg, wr[0], v, r, w, p)});
      end
  endtask

  initial begin
    logic [7:0] d;
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    rst = 0;
    // R3 reset state; R10 default routing
    chk("R10", {7'd0, route_int}, 8'h01);
    for (int i = 0; i < 256; i++) begin
      ior(8'(i), d);
      chk("R3", d, (i == 5) ? 8'h05 : (i == 8'h1B) ? 8'h60 : 8'h00);
    end
    chk("R9", {7'd0, fastrst_en}, 8'h00);
    chk("R8", {7'd0, ws_update}, 8'h00);
    // R2 non-data reads
    io_addr = 16'h22; io_rd = 1; #1 chk("R2", io_rdata, 8'hFF);
    io_addr = 16'h80; #1 chk("R2", io_rdata, 8'hFF);
    io_addr = 16'h23; io_rd = 0; #1 chk("R2", io_rdata, 8'hFF);
    // R1 write/readback all registers
    for (int i = 0; i < 256; i++) setreg(8'(i), 8'(i) ^ 8'h5A);
    for (int i = 0; i < 256; i++) begin
      ior(8'(i), d);
      chk("R1", d, 8'(i) ^ 8'h5A);
    end
    // R2 index-port write leaves content intact
    iow(16'h22, 8'h40); iow(16'h22, 8'h41);
    ior(8'h40, d); chk("R2", d, 8'h40 ^ 8'h5A);
    // R8 wait-state strobe
    iow(16'h22, 8'h06);
    iow(16'h23, 8'h33);
    chk("R8", {7'd0, ws_update}, 8'h01);
    @(negedge clk); chk("R8", {7'd0, ws_update}, 8'h00);
    iow(16'h22, 8'h07); iow(16'h23, 8'h11);
    chk("R8", {7'd0, ws_update}, 8'h00);
    iow(16'h22, 8'h06);
    chk("R8", {7'd0, ws_update}, 8'h00);
    // R9 fast reset enable
    setreg(8'h1C, 8'h20); chk("R9", {7'd0, fastrst_en}, 8'h01);
    setreg(8'h1C, 8'hDF); chk("R9", {7'd0, fastrst_en}, 8'h00);
    setreg(8'h1C, 8'hFF); chk("R9", {7'd0, fastrst_en}, 8'h01);
    // R4..R7, R10 routing sweeps
    sweep(8'h00, 8'h00, 8'h00, 8'h60);
    sweep(8'h03, 8'h7F, 8'h00, 8'hFF);
    sweep(8'h01, 8'h00, 8'h7F, 8'hFF);
    sweep(8'h02, 8'h55, 8'h2A, 8'h7F);
    sweep(8'h00, 8'h00, 8'h00, 8'h80);
    lf = 8'hA5;
    for (int k = 0; k < 48; k++) begin
      logic [7:0] a, b, c, e;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; a = lf;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; b = lf;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; c = lf;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]}; e = lf;
      sweep(a, b, c, e);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule